// File: doc/BRIEF.md
# Torus Source-Routed Hop Stage

This block makes the forwarding decision inside one switch of a two-dimensional torus network-on-chip. The switch has five outputs: one toward its own attached core and one toward each of its four neighbours in the positive and negative X and Y directions. Every packet header carries its origin, its final destination, a list of the moves still to be made and a count of how many of those moves remain. The route is worked out once at the source. Each switch only consumes the next move and does not compare coordinates to choose a direction.

When a header arrives whose destination matches the switch's own coordinates, the stage sends it to the local output unchanged. In every other case it takes the lowest two bits of the move list as the next step and picks the matching neighbour output. It shifts the move list down by one step and lowers the remaining count by one. It also reports the coordinate of the neighbour being reached, wrapping modulo the torus size at the edges. A header that is not for this switch but has no usable moves left is discarded, and a one-cycle error pulse is raised.

The decision is registered, so a header accepted on one clock edge is presented at the outputs right after that edge. Both sides use a valid/ready handshake, and the stage accepts one header per cycle while its output is drained.

Top module: `torus_hop_router`

## Requirements
- R1: While reset is asserted and directly after it, `out_valid` and `drop_err` are low.
- R2: A header whose destination equals (`my_x`,`my_y`) leaves on the local output (`out_port` bit 0). Its route, hop count, source and destination are unchanged, and `out_nbr_x`/`out_nbr_y` equal the local coordinates. This holds even when the hop count is zero.
- R3: For a header that is not for this switch, bits [1:0] of the route select the output port: 00 gives positive X (bit 1), 01 negative X (bit 2), 10 positive Y (bit 3) and 11 negative Y (bit 4).
- R4: A forwarded header leaves with its route shifted right by two bits with zero fill, its hop count reduced by one, and source and destination unchanged.
- R5: The reported neighbour coordinate is the local coordinate stepped by one along the chosen axis, modulo K. Stepping up from K-1 gives 0, and stepping down from 0 gives K-1.
- R6: A header accepted on a clock edge appears with `out_valid` high right after that edge. `out_valid` never rises without an accepted header.
- R7: A header that is not for this switch and has a hop count of 0 or above MAX_MOVES is dropped. No output is produced for it, and `drop_err` is high for exactly the one cycle after its acceptance.
- R8: While `out_valid` is high and `out_ready` is low, every output field holds its value.
- R9: `in_ready` is high exactly when the output register is empty or being consumed in the same cycle, so the stage sustains one header per cycle.
- R10: Whenever `out_valid` is high, exactly one bit of `out_port` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| my_x | input | CW | X coordinate of this switch |
| my_y | input | CW | Y coordinate of this switch |
| in_valid | input | 1 | Input header present |
| in_ready | output | 1 | Stage can take a header this cycle |
| in_src_x | input | CW | Origin X |
| in_src_y | input | CW | Origin Y |
| in_dst_x | input | CW | Destination X |
| in_dst_y | input | CW | Destination Y |
| in_route | input | 2*MAX_MOVES | Remaining moves, next move in bits [1:0] |
| in_hops | input | HW | Number of moves remaining |
| out_valid | output | 1 | Output header present |
| out_ready | input | 1 | Downstream takes the output header |
| out_port | output | 5 | One-hot output select: local, +X, -X, +Y, -Y |
| out_nbr_x | output | CW | X of the switch being reached |
| out_nbr_y | output | CW | Y of the switch being reached |
| out_src_x | output | CW | Origin X, passed through |
| out_src_y | output | CW | Origin Y, passed through |
| out_dst_x | output | CW | Destination X, passed through |
| out_dst_y | output | CW | Destination Y, passed through |
| out_route | output | 2*MAX_MOVES | Route after this hop |
| out_hops | output | HW | Hop count after this hop |
| drop_err | output | 1 | One-cycle pulse for a discarded header |

## Verification
The assertions assume that all coordinates on the inputs are below K and that `my_x`/`my_y` stay fixed while a header waits in the output register. The local-delivery and hop-count properties depend on that. The stimulus draws every coordinate in the range 0 to K-1, including both edges. It changes the switch position only together with a newly presented header. Hop counts are drawn from the full field width so that out-of-range values also occur.

// File: rtl/torus_route_pkg.sv
package torus_route_pkg;

  // Two-bit move code carried in the route field, next move in the low bits
  typedef enum logic [1:0] {
    MV_XP = 2'b00,
    MV_XM = 2'b01,
    MV_YP = 2'b10,
    MV_YM = 2'b11
  } move_e;

  localparam int PORT_N  = 5;
  localparam int P_LOCAL = 0;
  localparam int P_XP    = 1;
  localparam int P_XM    = 2;
  localparam int P_YP    = 3;
  localparam int P_YM    = 4;
  localparam int MOVE_W  = 2;

endpackage

// File: rtl/hop_rst_sync.sv
module hop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nx;

  always_comb begin
    chain_nx = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_nx;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/torus_wrap_step.sv
module torus_wrap_step #(
  parameter int K  = 4,
  parameter int CW = 2
) (
  input  logic [CW-1:0] coord_i,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] coord_o
);

  localparam logic [CW-1:0] TOP = CW'(K - 1);

  always_comb begin
    coord_o = coord_i;
    if (inc_i) begin
      coord_o = (coord_i == TOP) ? '0 : coord_i + 1'b1;
    end else if (dec_i) begin
      coord_o = (coord_i == '0) ? TOP : coord_i - 1'b1;
    end
  end

endmodule

// File: rtl/torus_hop_decode.sv
module torus_hop_decode
  import torus_route_pkg::*;
#(
  parameter int K         = 4,
  parameter int CW        = 2,
  parameter int MAX_MOVES = 12,
  parameter int RW        = 24,
  parameter int HW        = 4
) (
  input  logic [CW-1:0]     my_x,
  input  logic [CW-1:0]     my_y,
  input  logic [CW-1:0]     dst_x,
  input  logic [CW-1:0]     dst_y,
  input  logic [RW-1:0]     route,
  input  logic [HW-1:0]     hops,
  output logic              is_local,
  output logic              bad,
  output logic [PORT_N-1:0] port,
  output logic [CW-1:0]     nbr_x,
  output logic [CW-1:0]     nbr_y,
  output logic [RW-1:0]     route_nx,
  output logic [HW-1:0]     hops_nx
);

  localparam logic [HW-1:0] HOP_LIMIT = HW'(MAX_MOVES);

  move_e       move;
  logic        len_bad;
  logic [1:0]  step_inc;
  logic [1:0]  step_dec;
  logic [CW-1:0] here  [2];
  logic [CW-1:0] there [2];

  always_comb begin
    move     = move_e'(route[MOVE_W-1:0]);
    is_local = (dst_x == my_x) && (dst_y == my_y);
    len_bad  = (hops == '0) || (hops > HOP_LIMIT);
    bad      = !is_local && len_bad;
  end

  always_comb begin
    port = '0;
    if (is_local) begin
      port[P_LOCAL] = 1'b1;
    end else begin
      case (move)
        MV_XP:   port[P_XP] = 1'b1;
        MV_XM:   port[P_XM] = 1'b1;
        MV_YP:   port[P_YP] = 1'b1;
        default: port[P_YM] = 1'b1;
      endcase
    end
  end

  always_comb begin
    step_inc[0] = !is_local && (move == MV_XP);
    step_dec[0] = !is_local && (move == MV_XM);
    step_inc[1] = !is_local && (move == MV_YP);
    step_dec[1] = !is_local && (move == MV_YM);
    here[0]     = my_x;
    here[1]     = my_y;
  end

  for (genvar d = 0; d < 2; d++) begin : g_axis
    torus_wrap_step #(.K(K), .CW(CW)) u_step (
      .coord_i (here[d]),
      .inc_i   (step_inc[d]),
      .dec_i   (step_dec[d]),
      .coord_o (there[d])
    );
  end

  always_comb begin
    nbr_x    = there[0];
    nbr_y    = there[1];
    route_nx = is_local ? route : (route >> MOVE_W);
    hops_nx  = is_local ? hops  : (hops - 1'b1);
  end

endmodule

// File: rtl/hop_out_reg.sv
module hop_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance_en,
  input  logic         load_en,
  input  logic         valid_d,
  input  logic [W-1:0] data_d,
  output logic         valid_q,
  output logic [W-1:0] data_q
);

  logic valid_nx;

  always_comb begin
    valid_nx = advance_en ? valid_d : valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_nx;
  end

  always_ff @(posedge clk) begin
    if (load_en) data_q <= data_d;
  end

endmodule

// File: rtl/torus_hop_router.sv
module torus_hop_router
  import torus_route_pkg::*;
#(
  parameter int K         = 4,
  parameter int MAX_MOVES = 12,
  parameter int CW        = (K > 2) ? $clog2(K) : 1,
  parameter int HW        = $clog2(MAX_MOVES + 1),
  parameter int RW        = 2 * MAX_MOVES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] my_x,
  input  logic [CW-1:0] my_y,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_src_x,
  input  logic [CW-1:0] in_src_y,
  input  logic [CW-1:0] in_dst_x,
  input  logic [CW-1:0] in_dst_y,
  input  logic [RW-1:0] in_route,
  input  logic [HW-1:0] in_hops,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [4:0]    out_port,
  output logic [CW-1:0] out_nbr_x,
  output logic [CW-1:0] out_nbr_y,
  output logic [CW-1:0] out_src_x,
  output logic [CW-1:0] out_src_y,
  output logic [CW-1:0] out_dst_x,
  output logic [CW-1:0] out_dst_y,
  output logic [RW-1:0] out_route,
  output logic [HW-1:0] out_hops,
  output logic          drop_err
);

  localparam int PW = PORT_N + 6 * CW + RW + HW;

  logic              srst_n;
  logic              is_local;
  logic              bad;
  logic [PORT_N-1:0] dec_port;
  logic [CW-1:0]     dec_nbr_x;
  logic [CW-1:0]     dec_nbr_y;
  logic [RW-1:0]     dec_route;
  logic [HW-1:0]     dec_hops;
  logic              accept;
  logic              load_en;
  logic              valid_d;
  logic [PW-1:0]     pay_d;
  logic [PW-1:0]     pay_q;
  logic              err_q;
  logic              err_nx;

  hop_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  torus_hop_decode #(
    .K(K), .CW(CW), .MAX_MOVES(MAX_MOVES), .RW(RW), .HW(HW)
  ) u_dec (
    .my_x     (my_x),
    .my_y     (my_y),
    .dst_x    (in_dst_x),
    .dst_y    (in_dst_y),
    .route    (in_route),
    .hops     (in_hops),
    .is_local (is_local),
    .bad      (bad),
    .port     (dec_port),
    .nbr_x    (dec_nbr_x),
    .nbr_y    (dec_nbr_y),
    .route_nx (dec_route),
    .hops_nx  (dec_hops)
  );

  always_comb begin
    in_ready = !out_valid || out_ready;
    accept   = in_valid && in_ready;
    load_en  = accept && !bad;
    valid_d  = in_valid && !bad;
    pay_d    = {dec_port, dec_nbr_x, dec_nbr_y, in_src_x, in_src_y,
                in_dst_x, in_dst_y, dec_route, dec_hops};
    err_nx   = accept && bad;
  end

  hop_out_reg #(.W(PW)) u_out (
    .clk        (clk),
    .rst_n      (srst_n),
    .advance_en (in_ready),
    .load_en    (load_en),
    .valid_d    (valid_d),
    .data_d     (pay_d),
    .valid_q    (out_valid),
    .data_q     (pay_q)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) err_q <= 1'b0;
    else         err_q <= err_nx;
  end

  assign {out_port, out_nbr_x, out_nbr_y, out_src_x, out_src_y,
          out_dst_x, out_dst_y, out_route, out_hops} = pay_q;
  assign drop_err = err_q;

  logic unused_local;
  assign unused_local = is_local;

endmodule

// File: rtl/torus_hop_router_chk.sv
module torus_hop_router_chk #(
  parameter int K         = 4,
  parameter int MAX_MOVES = 12,
  parameter int CW        = 2,
  parameter int HW        = 4,
  parameter int RW        = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] my_x,
  input logic [CW-1:0] my_y,
  input logic          in_valid,
  input logic          in_ready,
  input logic [CW-1:0] in_src_x,
  input logic [CW-1:0] in_src_y,
  input logic [CW-1:0] in_dst_x,
  input logic [CW-1:0] in_dst_y,
  input logic [RW-1:0] in_route,
  input logic [HW-1:0] in_hops,
  input logic          out_valid,
  input logic          out_ready,
  input logic [4:0]    out_port,
  input logic [CW-1:0] out_nbr_x,
  input logic [CW-1:0] out_nbr_y,
  input logic [CW-1:0] out_src_x,
  input logic [CW-1:0] out_src_y,
  input logic [CW-1:0] out_dst_x,
  input logic [CW-1:0] out_dst_y,
  input logic [RW-1:0] out_route,
  input logic [HW-1:0] out_hops,
  input logic          drop_err
);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_port)
      && $stable(out_nbr_x) && $stable(out_nbr_y) && $stable(out_src_x)
      && $stable(out_src_y) && $stable(out_dst_x) && $stable(out_dst_y)
      && $stable(out_route) && $stable(out_hops)));

  // R9
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10
  port_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_port) == 1));

  // R2
  local_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_port[0]) |-> (out_nbr_x == out_dst_x && out_nbr_y == out_dst_y));

  // R7
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |-> !out_valid);

  // R4
  fwd_hops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_port[0]) |-> (out_hops < HW'(MAX_MOVES)));

  // R6
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));

endmodule

bind torus_hop_router torus_hop_router_chk #(
  .K(K), .MAX_MOVES(MAX_MOVES), .CW(CW), .HW(HW), .RW(RW)
) u_chk (.*);

// File: tb/torus_hop_router_bench.sv
module torus_hop_router_bench;
  localparam int K    = 5;
  localparam int MAXM = 12;
  localparam int CW   = 3;
  localparam int HW   = 4;
  localparam int RW   = 2 * MAXM;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] my_x, my_y;
  logic          in_valid, in_ready;
  logic [CW-1:0] in_src_x, in_src_y, in_dst_x, in_dst_y;
  logic [RW-1:0] in_route;
  logic [HW-1:0] in_hops;
  logic          out_valid, out_ready;
  logic [4:0]    out_port;
  logic [CW-1:0] out_nbr_x, out_nbr_y, out_src_x, out_src_y, out_dst_x, out_dst_y;
  logic [RW-1:0] out_route;
  logic [HW-1:0] out_hops;
  logic          drop_err;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  torus_hop_router #(.K(K), .MAX_MOVES(MAXM)) u_torus_hop_router (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_src_x(in_src_x), .in_src_y(in_src_y), .in_dst_x(in_dst_x), .in_dst_y(in_dst_y),
    .in_route(in_route), .in_hops(in_hops),
    .out_valid(out_valid), .out_ready(out_ready), .out_port(out_port),
    .out_nbr_x(out_nbr_x), .out_nbr_y(out_nbr_y),
    .out_src_x(out_src_x), .out_src_y(out_src_y),
    .out_dst_x(out_dst_x), .out_dst_y(out_dst_y),
    .out_route(out_route), .out_hops(out_hops), .drop_err(drop_err)
  );

  // Behavioural reference model, updated on each rising edge
  int m_valid, m_err, m_port, m_nx, m_ny, m_sx, m_sy, m_dx, m_dy, m_hops;
  logic [RW-1:0] m_route;

  always @(posedge clk or negedge rst_n) begin
    int rdy, mx, myy, mv;
    if (!rst_n) begin
      m_valid = 0;
      m_err   = 0;
    end else begin
      rdy   = (m_valid == 0 || out_ready) ? 1 : 0;
      m_err = 0;
      if (rdy == 1) begin
        if (in_valid) begin
          mx  = int'(my_x);
          myy = int'(my_y);
          if (int'(in_dst_x) == mx && int'(in_dst_y) == myy) begin
            m_valid = 1; m_port = 0; m_nx = mx; m_ny = myy;
            m_route = in_route; m_hops = int'(in_hops);
            m_sx = int'(in_src_x); m_sy = int'(in_src_y);
            m_dx = int'(in_dst_x); m_dy = int'(in_dst_y);
          end else if (int'(in_hops) == 0 || int'(in_hops) > MAXM) begin
            m_valid = 0; m_err = 1;
          end else begin
            mv = int'(in_route[1:0]);
            m_valid = 1; m_port = mv + 1; m_nx = mx; m_ny = myy;
            if (mv == 0) m_nx = (mx + 1) % K;
            if (mv == 1) m_nx = (mx + K - 1) % K;
            if (mv == 2) m_ny = (myy + 1) % K;
            if (mv == 3) m_ny = (myy + K - 1) % K;
            m_route = in_route / (1 << 2);
            m_hops  = int'(in_hops) - 1;
            m_sx = int'(in_src_x); m_sy = int'(in_src_y);
            m_dx = int'(in_dst_x); m_dy = int'(in_dst_y);
          end
        end else begin
          m_valid = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    int exp_rdy;
    exp_rdy = (m_valid == 0 || out_ready) ? 1 : 0;
    check(int'(in_ready) == exp_rdy, "R9 in_ready", in_ready, exp_rdy);
    check(int'(out_valid) == m_valid, "R6/R8 out_valid", out_valid, m_valid);
    check(int'(drop_err) == m_err, "R7 drop_err", drop_err, m_err);
    if (m_valid == 1 && out_valid) begin
      check(out_port == 5'(1 << m_port), (m_port == 0) ? "R2 port" : "R3 port", out_port, 1 << m_port);
      check($countones(out_port) == 1, "R10 onehot", out_port, 1);
      check(int'(out_nbr_x) == m_nx && int'(out_nbr_y) == m_ny, "R5 nbr",
            int'(out_nbr_x) * 16 + int'(out_nbr_y), m_nx * 16 + m_ny);
      check(out_route == m_route, "R4 route", out_route, m_route);
      check(int'(out_hops) == m_hops, "R4 hops", out_hops, m_hops);
      check(int'(out_src_x) == m_sx && int'(out_src_y) == m_sy &&
            int'(out_dst_x) == m_dx && int'(out_dst_y) == m_dy, "R4 src_dst",
            int'(out_dst_x) * 16 + int'(out_dst_y), m_dx * 16 + m_dy);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic put(input int mx, input int myy, input int dx, input int dy,
                     input logic [RW-1:0] rt, input int h);
    my_x = CW'(mx); my_y = CW'(myy);
    in_src_x = CW'((mx + 2) % K); in_src_y = CW'((myy + 3) % K);
    in_dst_x = CW'(dx); in_dst_y = CW'(dy);
    in_route = rt; in_hops = HW'(h);
    in_valid = 1'b1;
    tick();
    in_valid = 1'b0;
  endtask

  function automatic logic [RW-1:0] mk(input int a, input int b, input int c);
    logic [RW-1:0] r;
    r = '0;
    r[1:0] = 2'(a); r[3:2] = 2'(b); r[5:4] = 2'(c);
    return r;
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog act=%0d exp=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cx, cy;
    logic [RW-1:0] crt;
    int ch;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    my_x = '0; my_y = '0; in_src_x = '0; in_src_y = '0;
    in_dst_x = '0; in_dst_y = '0; in_route = '0; in_hops = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!out_valid && !drop_err, "R1 reset", {out_valid, drop_err}, 0);
    rst_n = 1'b1;
    repeat (5) tick();
    check(!out_valid && !drop_err, "R1 after release", {out_valid, drop_err}, 0);

    // R2 local delivery, including zero hop count
    put(2, 3, 2, 3, mk(1, 2, 3), 3); tick();
    put(4, 0, 4, 0, '0, 0); tick();
    // R3 each move from the centre
    put(2, 2, 0, 0, mk(0, 1, 2), 4);
    put(2, 2, 0, 0, mk(1, 0, 0), 4);
    put(2, 2, 0, 0, mk(2, 3, 0), 4);
    put(2, 2, 0, 0, mk(3, 3, 3), 4); tick();
    // R5 wrap at each edge
    put(4, 0, 1, 1, mk(0, 0, 0), 2);
    put(0, 0, 1, 1, mk(1, 0, 0), 2);
    put(1, 4, 3, 3, mk(2, 0, 0), 2);
    put(1, 0, 3, 3, mk(3, 0, 0), 2); tick();
    // R7 drops
    put(1, 1, 3, 2, mk(0, 0, 0), 0); tick();
    check(!out_valid, "R7 no output hops0", out_valid, 0);
    put(1, 1, 3, 2, mk(0, 0, 0), 13); tick();
    check(!out_valid, "R7 no output hops13", out_valid, 0);

    // R8 stall: hold output, offer a second header meanwhile
    out_ready = 1'b0;
    put(3, 3, 0, 1, mk(2, 1, 0), 5);
    my_x = CW'(1); my_y = CW'(1); in_dst_x = CW'(0); in_dst_y = CW'(0);
    in_route = mk(3, 0, 0); in_hops = HW'(3); in_valid = 1'b1;
    repeat (3) tick();
    check(out_valid && out_port == 5'b01000, "R8 held", out_port, 5'b01000);
    out_ready = 1'b1;
    tick();
    in_valid = 1'b0;
    tick();
    tick();

    // R4 multi-hop walk from (0,0) to (2,1): +X +X +Y, then local
    cx = 0; cy = 0; crt = mk(0, 0, 2); ch = 3;
    for (int s = 0; s < 4; s++) begin
      put(cx, cy, 2, 1, crt, ch);
      cx = int'(out_nbr_x); cy = int'(out_nbr_y); crt = out_route; ch = int'(out_hops);
    end
    check(out_port == 5'b00001 && out_hops == '0, "R4 walk arrives local", out_port, 1);

    // Mixed traffic
    for (int i = 0; i < 4000; i++) begin
      int mx, myy;
      out_ready = ($urandom_range(0, 9) < 7);
      if (!in_valid || in_ready) begin
        mx = $urandom_range(0, K - 1); myy = $urandom_range(0, K - 1);
        my_x = CW'(mx); my_y = CW'(myy);
        in_src_x = CW'($urandom_range(0, K - 1)); in_src_y = CW'($urandom_range(0, K - 1));
        if ($urandom_range(0, 3) == 0) begin
          in_dst_x = CW'(mx); in_dst_y = CW'(myy);
        end else begin
          in_dst_x = CW'($urandom_range(0, K - 1)); in_dst_y = CW'($urandom_range(0, K - 1));
        end
        in_route = RW'({$urandom(), $urandom()});
        in_hops  = HW'($urandom_range(0, 15));
        in_valid = ($urandom_range(0, 3) != 0);
      end
      tick();
    end
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule